// File: doc/BRIEF.md
# Serial Controller Register and Status Block

This block is the CPU-facing side of an asynchronous serial controller. It holds two control registers, a status register and a data window, all one byte wide on a small register bus. It tracks when the transmit holding byte is free and when a frame has finished leaving the line. It also keeps the flags for a received byte waiting, a lost byte (overrun), an idle line, noise and framing errors. From these flags and the enable bits it raises a single interrupt request.

Bit-level shifting is done elsewhere. A transmit shifter takes a one-cycle load strobe with a byte and later returns a one-cycle done strobe. A receiver delivers a one-cycle strobe with the byte and its error qualifiers. The block tells both shifters the frame length in bits. Receive flags clear through a read of the status register followed by a read of the data window. Only the flags seen by that status read are cleared.

Top module: `serial_regs`

## Requirements
- R1: After reset both control registers read 0x00, the status register reads 0xC0 (only transmit-empty, bit 7, and transmit-complete, bit 6, set), and irq is low. Register offsets are: 0 control 1, 1 control 2, 2 status, 3 data. Status layout from bit 7 down: empty, complete, receive-full, idle, overrun, noise, framing, 0.
- R2: Writes to the status offset change nothing that can be read back.
- R3: `frame_bits` is 10 when control 1 bit 4 is 0 and 11 when it is 1.
- R4: A data write is accepted only while transmit-empty is set. A data write made while it is clear is dropped, and `tx_byte` keeps the earlier byte.
- R5: When a byte is pending and transmit-enable (control 2 bit 3) is set with no frame in flight, `tx_load` pulses for one cycle with the byte, on the second clock edge after an accepted write. Transmit-empty and transmit-complete then both read 0. No load occurs while transmit-enable is clear; the load follows once the bit is set.
- R6: A `tx_done` strobe for the frame in flight sets transmit-empty and transmit-complete again.
- R7: A received byte sets receive-full and is returned by a data read. If receive-full was already set, overrun is also set. Noise and framing qualifiers set their flags.
- R8: A status read records which of receive-full, idle, overrun, noise and framing are set. The next data read clears exactly those flags and no others.
- R9: Any register write between that status read and the data read cancels the record, so that the data read clears nothing.
- R10: While receive-enable (control 2 bit 2) is clear, received bytes and idle strobes are discarded.
- R11: `irq` is high when any of these holds: control 2 bit 7 with transmit-empty; bit 6 with transmit-complete; bit 5 with receive-full or overrun; bit 4 with idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 write, 0 read |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| frame_bits | output | FW | Frame length in bits, start and stop included |
| tx_load | output | 1 | Start strobe to the transmit shifter |
| tx_byte | output | 8 | Byte to transmit |
| tx_done | input | 1 | Frame-finished strobe from the shifter |
| rx_valid | input | 1 | Byte-received strobe |
| rx_byte | input | 8 | Received byte |
| rx_noise | input | 1 | Noise seen on this byte |
| rx_frame | input | 1 | Framing error on this byte |
| rx_idle | input | 1 | Idle-line strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default frame lengths of 10 and 11 bits and a 4-bit length field. This puts both mode encodings in view. Directed cases cover the transmit handshake, dropped writes and a start held back until enable. A seeded random mix of received bytes, error qualifiers, idle strobes, status and data reads and enable writes covers the clearing sequence against a bench model. That mix reaches overrun on back-to-back bytes, partial clears of flags set after a status read, and a record cancelled by a write.

// File: rtl/serial_regs.sv
module serial_regs #(
  parameter int SHORT_FRAME = 10,
  parameter int LONG_FRAME  = 11,
  parameter int FW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [FW-1:0] frame_bits,
  output logic          tx_load,
  output logic [7:0]    tx_byte,
  input  logic          tx_done,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_noise,
  input  logic          rx_frame,
  input  logic          rx_idle,
  output logic          irq
);
  localparam logic [1:0] A_CTL1 = 2'd0, A_CTL2 = 2'd1, A_STAT = 2'd2, A_DATA = 2'd3;
  localparam int B_LONG = 4;
  localparam int B_TIE = 7, B_TCIE = 6, B_RIE = 5, B_ILIE = 4, B_TE = 3, B_RE = 2;

  logic [7:0] ctl1, ctl2, rx_data, tx_hold;
  logic       tdre, tc, rdrf, idle, ovr, nf, fe;
  logic [4:0] pend, flags, clr;
  logic       pending, busy, start;

  wire wr      = cs & we;
  wire rd_stat = cs & ~we & (addr == A_STAT);
  wire rd_data = cs & ~we & (addr == A_DATA);
  wire wr_data = wr & (addr == A_DATA);
  wire rx_take = rx_valid & ctl2[B_RE];
  wire [7:0] status = {tdre, tc, rdrf, idle, ovr, nf, fe, 1'b0};

  assign flags      = {rdrf, idle, ovr, nf, fe};
  assign clr        = rd_data ? pend : 5'b0;
  assign start      = pending & ctl2[B_TE] & ~busy;
  assign tx_byte    = tx_hold;
  assign frame_bits = ctl1[B_LONG] ? FW'(LONG_FRAME) : FW'(SHORT_FRAME);
  assign irq = (ctl2[B_TIE] & tdre) | (ctl2[B_TCIE] & tc) |
               (ctl2[B_RIE] & (rdrf | ovr)) | (ctl2[B_ILIE] & idle);

  always_comb begin
    case (addr)
      A_CTL1:  rdata = ctl1;
      A_CTL2:  rdata = ctl2;
      A_STAT:  rdata = status;
      default: rdata = rx_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl1 <= '0; ctl2 <= '0; rx_data <= '0; tx_hold <= '0;
      tdre <= 1'b1; tc <= 1'b1;
      rdrf <= 1'b0; idle <= 1'b0; ovr <= 1'b0; nf <= 1'b0; fe <= 1'b0;
      pend <= '0; pending <= 1'b0; busy <= 1'b0; tx_load <= 1'b0;
    end else begin
      tx_load <= start;
      if (wr && addr == A_CTL1) ctl1 <= wdata;
      if (wr && addr == A_CTL2) ctl2 <= wdata;
      if (wr_data && tdre) begin
        tx_hold <= wdata;
        pending <= 1'b1;
      end
      if (start) begin
        pending <= 1'b0; busy <= 1'b1; tdre <= 1'b0; tc <= 1'b0;
      end else if (tx_done && busy) begin
        busy <= 1'b0; tdre <= 1'b1; tc <= 1'b1;
      end
      if (rx_take) rx_data <= rx_byte;
      rdrf <= rx_take | (rdrf & ~clr[4]);
      idle <= (rx_idle & ctl2[B_RE]) | (idle & ~clr[3]);
      ovr  <= (rx_take & rdrf) | (ovr & ~clr[2]);
      nf   <= (rx_take & rx_noise) | (nf & ~clr[1]);
      fe   <= (rx_take & rx_frame) | (fe & ~clr[0]);
      if (wr || rd_data) pend <= '0;
      else if (rd_stat)  pend <= flags;
    end
  end

  assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take && rdrf) |=> (ovr && rdrf));
  assert_full_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdrf) |-> $past(rx_valid));
  assert_drop_keeps_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !tdre) |=> $stable(tx_byte));
  assert_load_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (!tdre && !tc));
  assert_empty_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdre) |-> $past(tx_done));
  assert_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ctl2[B_RE] && !rdrf) |=> !rdrf);
endmodule

// File: tb/test_serial_regs.sv
module test_serial_regs;
  logic clk = 0, rst_n = 0, cs = 0, we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, tx_byte, rx_byte = 0;
  logic [3:0] frame_bits;
  logic tx_load, tx_done = 0, rx_valid = 0, rx_noise = 0, rx_frame = 0, rx_idle = 0, irq;
  int n_tests = 0, n_fail = 0;

  serial_regs i_serial_regs (.clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .frame_bits(frame_bits), .tx_load(tx_load),
    .tx_byte(tx_byte), .tx_done(tx_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_noise(rx_noise), .rx_frame(rx_frame), .rx_idle(rx_idle), .irq(irq));

  always #2 clk = ~clk;

  // bench model of receive side and control 2
  logic m_rdrf = 0, m_idle = 0, m_or = 0, m_nf = 0, m_fe = 0;
  logic [4:0] m_pend = 0;
  logic [7:0] m_data = 0, m_ctl2 = 0;

  function automatic logic [7:0] exp_status(input logic tdre, input logic tc);
    return {tdre, tc, m_rdrf, m_idle, m_or, m_nf, m_fe, 1'b0};
  endfunction
  function automatic logic exp_irq(input logic tdre, input logic tc);
    return (m_ctl2[7] & tdre) | (m_ctl2[6] & tc) | (m_ctl2[5] & (m_rdrf | m_or)) | (m_ctl2[4] & m_idle);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
    m_pend = 0;
    if (a == 2'd1) m_ctl2 = d;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a; #1 d = rdata;
    @(negedge clk); cs = 0;
    if (a == 2'd2) m_pend = {m_rdrf, m_idle, m_or, m_nf, m_fe};
    if (a == 2'd3) begin
      {m_rdrf, m_idle, m_or, m_nf, m_fe} = {m_rdrf, m_idle, m_or, m_nf, m_fe} & ~m_pend;
      m_pend = 0;
    end
  endtask

  task automatic rx(input logic [7:0] b, input logic nz, input logic fr);
    @(negedge clk); rx_valid = 1; rx_byte = b; rx_noise = nz; rx_frame = fr;
    @(negedge clk); rx_valid = 0; rx_noise = 0; rx_frame = 0;
    if (m_ctl2[2]) begin
      m_or = m_or | m_rdrf; m_rdrf = 1; m_data = b; m_nf = m_nf | nz; m_fe = m_fe | fr;
    end
  endtask

  task automatic idle_pulse();
    @(negedge clk); rx_idle = 1;
    @(negedge clk); rx_idle = 0;
    if (m_ctl2[2]) m_idle = 1;
  endtask

  task automatic done_pulse();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(2'd2, v); check("R1 status", v, 8'hC0);
    rd(2'd0, v); check("R1 ctl1", v, 8'h00);
    rd(2'd1, v); check("R1 ctl2", v, 8'h00);
    check("R1 irq", irq, 0);
    // R2
    wr(2'd2, 8'hFF); rd(2'd2, v); check("R2 status write ignored", v, 8'hC0);
    // R3
    check("R3 short frame", frame_bits, 10);
    wr(2'd0, 8'h10); check("R3 long frame", frame_bits, 11);
    wr(2'd0, 8'h00); check("R3 back to short", frame_bits, 10);
    // R5/R6/R4 transmit
    wr(2'd1, 8'h08);
    @(negedge clk); cs = 1; we = 1; addr = 2'd3; wdata = 8'h5A;
    @(negedge clk); cs = 0; we = 0; m_pend = 0;
    check("R5 no load yet", tx_load, 0);
    @(negedge clk);
    check("R5 load pulse", tx_load, 1);
    check("R5 load byte", tx_byte, 8'h5A);
    rd(2'd2, v); check("R5 empty and complete cleared", v, 8'h00);
    check("R5 load one cycle", tx_load, 0);
    wr(2'd3, 8'h77);
    check("R4 dropped write keeps byte", tx_byte, 8'h5A);
    done_pulse();
    rd(2'd2, v); check("R6 flags set by done", v, 8'hC0);
    check("R4 dropped write not sent", tx_load, 0);
    // R5 with enable clear
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h33);
    repeat (3) begin @(negedge clk); check("R5 no load while disabled", tx_load, 0); end
    rd(2'd2, v); check("R5 pending disabled status", v, 8'hC0);
    wr(2'd3, 8'h44);
    @(negedge clk); cs = 1; we = 1; addr = 2'd1; wdata = 8'h08;
    @(negedge clk); cs = 0; we = 0; m_ctl2 = 8'h08;
    @(negedge clk);
    check("R5 load after enable", tx_load, 1);
    check("R4 overwrite while empty", tx_byte, 8'h44);
    done_pulse();
    rd(2'd2, v); check("R6 done again", v, 8'hC0);
    // R10
    wr(2'd1, 8'h00);
    rx(8'hAB, 1, 1); idle_pulse();
    rd(2'd2, v); check("R10 discarded", v, 8'hC0);
    // R11
    wr(2'd1, 8'h80); check("R11 tie irq", irq, 1);
    wr(2'd1, 8'h20); check("R11 rie no flag", irq, 0);
    // R7/R8
    wr(2'd1, 8'h24);
    rx(8'h11, 0, 0);
    check("R11 rie irq", irq, 1);
    rx(8'h22, 0, 0);
    rd(2'd2, v); check("R7 overrun", v, 8'hE8);
    rd(2'd3, v); check("R7 latest byte", v, 8'h22);
    rd(2'd2, v); check("R8 cleared", v, 8'hC0);
    // R8 partial: flag arriving after status read survives
    rx(8'h55, 0, 0);
    rd(2'd2, v);
    idle_pulse();
    rd(2'd3, v2); check("R8 data", v2, 8'h55);
    rd(2'd2, v); check("R8 later idle kept", v, 8'hD0);
    rd(2'd3, v);
    // R9
    rx(8'h66, 0, 0);
    rd(2'd2, v);
    wr(2'd0, 8'h00);
    rd(2'd3, v);
    rd(2'd2, v); check("R9 write cancels clear", v, 8'hE0);
    rd(2'd3, v);
    rd(2'd2, v); check("R9 normal clear", v, 8'hC0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: rx(8'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
        1: idle_pulse();
        2: begin rd(2'd2, v); check("R8 random status", v, exp_status(1, 1)); end
        3: begin
             v2 = m_data;
             rd(2'd3, v); check("R7 random data", v, v2);
           end
        4: wr(2'd1, {4'($urandom), 4'b0100});
        default: begin
             rd(2'd2, v);
             rd(2'd3, v);
             rd(2'd2, v); check("R8 random sequence", v, exp_status(1, 1));
           end
      endcase
      check("R11 random irq", irq, exp_irq(1, 1));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule